// File: doc/BRIEF.md
# Queued Output Match Sequencer

This block drives a single output pin from a short table of timed events. Each table entry holds a time step and the level the pin should take when that step expires. After a start, the sequencer adds the first step to a reference time, waits until a free-running timebase reaches the sum, drives the entry's level onto the pin, then adds the next step to that match time. Because every target is built from the previous one, the intervals never drift, and all arithmetic wraps with the timebase.

A pass through the table can be played once, a programmed number of times, or without end. The pass length is chosen per run. A start comes from a software strobe or from a link strobe that another channel raises. The reference time is either the local timebase or a time value supplied by a neighbouring channel. A table whose entries all carry the same level holds the pin steadily high or low, which gives the 100% and 0% extremes of a PWM pattern. A direct-drive mode bypasses the table and lets the pin follow a static input.

Top module: `qom_seq`

## Requirements
- R1: While reset is asserted and after its release, `pin`, `busy` and `done` are 0 and the timebase `tnow` restarts from 0.
- R2: `tnow` advances by exactly one every clock and wraps from 2^TW-1 to 0.
- R3: A start (`sw_start` or `link_start` high while `drv_mode` is 0) latches the reference time from `tnow` when `ref_sel` is 0, or from `ref_time` when `ref_sel` is 1. It then sets `busy` to 1 and `done` to 0 on the next cycle. Raising both strobes in the same cycle counts as one start.
- R4: The match time of entry 0 is the reference time plus its step. Each later match is the previous match time plus that entry's step, taken modulo 2^TW. A step of 0 stands for a full timebase period. The pin shows the entry's level from the cycle after `tnow` equals the match time.
- R5: A pass covers table entries 0 through `last_idx` and no others. `last_idx` is captured at start.
- R6: In loop mode 0 (once), the match of entry `last_idx` sets `done` to 1 and clears `busy`. While idle, the pin keeps its last level.
- R7: In loop mode 1 (counted), the table is played `loop_count` times, with a count of 0 behaving as 1. Each new pass starts from the last match time, and `done` rises only after the final pass.
- R8: In loop mode 2 (continuous), the pass repeats indefinitely and `done` never rises. Mode 3 behaves as mode 0.
- R9: While `drv_mode` is 1, the pin takes `drv_val` one cycle later, any running sequence stops with `busy` and `done` at 0, and both start strobes are ignored.
- R10: A continuous table whose levels are all 1 (or all 0) keeps the pin constantly high (or low) after its first match.
- R11: A start while `busy` is 1 discards the running schedule and restarts from entry 0 with a new reference time.
- R12: Match times that cross the timebase wrap point are reached at the correct wrapped count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Table entry write enable |
| tbl_addr | input | AW | Table entry index to write |
| tbl_step | input | TW | Time step to store |
| tbl_lvl | input | 1 | Pin level to store |
| loop_mode | input | 2 | 0 once, 1 counted, 2 continuous, 3 once |
| loop_count | input | CW | Number of passes in counted mode |
| last_idx | input | AW | Index of the last entry of a pass |
| ref_sel | input | 1 | 1 takes the reference time from `ref_time` |
| ref_time | input | TW | Reference time from a neighbouring channel |
| sw_start | input | 1 | Software start strobe |
| link_start | input | 1 | Start strobe from another channel |
| drv_mode | input | 1 | Direct pin-drive mode |
| drv_val | input | 1 | Pin level in direct mode |
| tnow | output | TW | Free-running timebase |
| pin | output | 1 | Sequenced output pin |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Final pass completed |

## Verification
The bench builds the block with TW=10, DEPTH=4 and CW=4. A 10-bit timebase wraps every 1024 cycles, so a zero step that means a full period, and a schedule that straddles the wrap, can both be run to completion in a few thousand cycles. Four entries let a pass use a strict subset of the table, with a trailing entry that must never fire, and also let the table be filled completely. A 4-bit loop count still covers the zero-means-one rule and multi-pass runs.

// File: rtl/qom_pkg.sv
package qom_pkg;

  typedef enum logic [1:0] {
    LOOP_ONCE    = 2'd0,
    LOOP_COUNTED = 2'd1,
    LOOP_ENDLESS = 2'd2,
    LOOP_SPARE   = 2'd3
  } loop_mode_e;

endpackage

// File: rtl/qom_timebase.sv
module qom_timebase #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [TW-1:0] count
);

  logic [TW-1:0] count_n;

  always_comb begin
    count_n = count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_n;
  end

endmodule

// File: rtl/qom_table.sv
module qom_table #(
  parameter int TW    = 16,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [TW-1:0] wstep,
  input  logic          wlvl,
  input  logic [AW-1:0] step_idx,
  output logic [TW-1:0] step_rd,
  input  logic [AW-1:0] lvl_idx,
  output logic          lvl_rd
);

  logic [TW-1:0] step_mem [DEPTH];
  logic          lvl_mem  [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic wen;
    assign wen = we && (waddr == AW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        step_mem[i] <= '0;
        lvl_mem[i]  <= 1'b0;
      end else if (wen) begin
        step_mem[i] <= wstep;
        lvl_mem[i]  <= wlvl;
      end
    end
  end

  assign step_rd = step_mem[step_idx];
  assign lvl_rd  = lvl_mem[lvl_idx];

endmodule

// File: rtl/qom_match.sv
module qom_match #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          advance,
  input  logic [TW-1:0] base,
  input  logic [TW-1:0] step,
  input  logic [TW-1:0] now,
  output logic [TW-1:0] target,
  output logic          equal
);

  logic [TW-1:0] target_n;

  always_comb begin
    target_n = target;
    if (load)         target_n = base + step;
    else if (advance) target_n = target + step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) target <= '0;
    else        target <= target_n;
  end

  assign equal = (now == target);

endmodule

// File: rtl/qom_loop.sv
module qom_loop
  import qom_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [1:0]    mode_in,
  input  logic [CW-1:0] count_in,
  input  logic          pass_end,
  output logic          again,
  output loop_mode_e    mode_q
);

  logic [CW-1:0] left_q, left_n;
  loop_mode_e    mode_n;
  logic          more_left;

  assign more_left = (left_q > CW'(1));

  always_comb begin
    mode_n = mode_q;
    left_n = left_q;
    if (load) begin
      mode_n = loop_mode_e'(mode_in);
      left_n = (count_in == '0) ? CW'(1) : count_in;
    end else if (pass_end && mode_q == LOOP_COUNTED && more_left) begin
      left_n = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= LOOP_ONCE;
      left_q <= '0;
    end else begin
      mode_q <= mode_n;
      left_q <= left_n;
    end
  end

  assign again = (mode_q == LOOP_ENDLESS) ||
                 ((mode_q == LOOP_COUNTED) && more_left);

endmodule

// File: rtl/qom_seq.sv
module qom_seq
  import qom_pkg::*;
#(
  parameter int TW    = 16,
  parameter int DEPTH = 8,
  parameter int CW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tbl_we,
  input  logic [AW-1:0] tbl_addr,
  input  logic [TW-1:0] tbl_step,
  input  logic          tbl_lvl,
  input  logic [1:0]    loop_mode,
  input  logic [CW-1:0] loop_count,
  input  logic [AW-1:0] last_idx,
  input  logic          ref_sel,
  input  logic [TW-1:0] ref_time,
  input  logic          sw_start,
  input  logic          link_start,
  input  logic          drv_mode,
  input  logic          drv_val,
  output logic [TW-1:0] tnow,
  output logic          pin,
  output logic          busy,
  output logic          done
);

  logic          busy_q, busy_n;
  logic          done_q, done_n;
  logic          pin_q, pin_n;
  logic [AW-1:0] idx_q, idx_n;
  logic [AW-1:0] last_q, last_n;

  logic          start, hit, at_last, pass_end, again, finish, advance;
  logic [AW-1:0] next_idx;
  logic [TW-1:0] step_rd, base_sel, target;
  logic          lvl_rd, equal;
  loop_mode_e    mode_cur;

  qom_timebase #(.TW(TW)) u_tb (
    .clk   (clk),
    .rst_n (rst_n),
    .count (tnow)
  );

  assign start    = (sw_start | link_start) & ~drv_mode;
  assign hit      = busy_q & equal & ~drv_mode & ~start;
  assign at_last  = (idx_q == last_q);
  assign pass_end = hit & at_last;
  assign finish   = pass_end & ~again;
  assign advance  = hit & ~finish;
  assign base_sel = ref_sel ? ref_time : tnow;

  always_comb begin
    if (start || at_last) next_idx = '0;
    else                  next_idx = idx_q + 1'b1;
  end

  qom_table #(.TW(TW), .DEPTH(DEPTH)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (tbl_we),
    .waddr    (tbl_addr),
    .wstep    (tbl_step),
    .wlvl     (tbl_lvl),
    .step_idx (next_idx),
    .step_rd  (step_rd),
    .lvl_idx  (idx_q),
    .lvl_rd   (lvl_rd)
  );

  qom_match #(.TW(TW)) u_match (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start),
    .advance (advance),
    .base    (base_sel),
    .step    (step_rd),
    .now     (tnow),
    .target  (target),
    .equal   (equal)
  );

  qom_loop #(.CW(CW)) u_loop (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start),
    .mode_in  (loop_mode),
    .count_in (loop_count),
    .pass_end (pass_end),
    .again    (again),
    .mode_q   (mode_cur)
  );

  always_comb begin
    busy_n = busy_q;
    done_n = done_q;
    pin_n  = pin_q;
    idx_n  = idx_q;
    last_n = last_q;
    if (drv_mode) begin
      busy_n = 1'b0;
      done_n = 1'b0;
      pin_n  = drv_val;
    end else if (start) begin
      busy_n = 1'b1;
      done_n = 1'b0;
      idx_n  = '0;
      last_n = last_idx;
    end else if (hit) begin
      pin_n = lvl_rd;
      idx_n = next_idx;
      if (finish) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      pin_q  <= 1'b0;
      idx_q  <= '0;
      last_q <= '0;
    end else begin
      busy_q <= busy_n;
      done_q <= done_n;
      pin_q  <= pin_n;
      idx_q  <= idx_n;
      last_q <= last_n;
    end
  end

  assign pin  = pin_q;
  assign busy = busy_q;
  assign done = done_q;

endmodule

// File: rtl/qom_seq_chk.sv
module qom_seq_chk #(
  parameter int TW = 16,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sw_start,
  input logic          link_start,
  input logic          drv_mode,
  input logic          drv_val,
  input logic [TW-1:0] tnow,
  input logic          pin,
  input logic          busy,
  input logic          done,
  input logic [1:0]    mode_cur,
  input logic [AW-1:0] idx_q,
  input logic [AW-1:0] last_q
);

  p_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (tnow == $past(tnow) + 1'b1));

  p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((sw_start || link_start) && !drv_mode) |=> (busy && !done));

  p_idx_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (idx_q <= last_q));

  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !drv_mode) |=> $stable(pin));

  p_endless_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !drv_mode && mode_cur == 2'd2) |=> !done);

  p_direct_r9: assert property (@(posedge clk) disable iff (!rst_n)
    drv_mode |=> (pin == $past(drv_val)) && !busy && !done);

endmodule

bind qom_seq qom_seq_chk #(.TW(TW), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sw_start   (sw_start),
  .link_start (link_start),
  .drv_mode   (drv_mode),
  .drv_val    (drv_val),
  .tnow       (tnow),
  .pin        (pin),
  .busy       (busy),
  .done       (done),
  .mode_cur   (mode_cur),
  .idx_q      (idx_q),
  .last_q     (last_q)
);

// File: tb/qom_seq_tb.sv
module qom_seq_tb;

  localparam int TW    = 10;
  localparam int DEPTH = 4;
  localparam int CW    = 4;
  localparam int AW    = $clog2(DEPTH);

  logic          clk;
  logic          rst_n;
  logic          tbl_we;
  logic [AW-1:0] tbl_addr;
  logic [TW-1:0] tbl_step;
  logic          tbl_lvl;
  logic [1:0]    loop_mode;
  logic [CW-1:0] loop_count;
  logic [AW-1:0] last_idx;
  logic          ref_sel;
  logic [TW-1:0] ref_time;
  logic          sw_start;
  logic          link_start;
  logic          drv_mode;
  logic          drv_val;
  logic [TW-1:0] tnow;
  logic          pin;
  logic          busy;
  logic          done;

  int nchk = 0;
  int nerr = 0;
  logic          exp_pin;
  logic [TW-1:0] steps [DEPTH];
  logic          lvls  [DEPTH];

  qom_seq #(.TW(TW), .DEPTH(DEPTH), .CW(CW)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .tbl_we     (tbl_we),
    .tbl_addr   (tbl_addr),
    .tbl_step   (tbl_step),
    .tbl_lvl    (tbl_lvl),
    .loop_mode  (loop_mode),
    .loop_count (loop_count),
    .last_idx   (last_idx),
    .ref_sel    (ref_sel),
    .ref_time   (ref_time),
    .sw_start   (sw_start),
    .link_start (link_start),
    .drv_mode   (drv_mode),
    .drv_val    (drv_val),
    .tnow       (tnow),
    .pin        (pin),
    .busy       (busy),
    .done       (done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic load_table(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tbl_we   = 1'b1;
      tbl_addr = AW'(i);
      tbl_step = steps[i];
      tbl_lvl  = lvls[i];
    end
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic wait_t(input logic [TW-1:0] v);
    while (tnow !== v) @(negedge clk);
  endtask

  task automatic do_start(input bit sw, input bit lk, output logic [TW-1:0] t0);
    @(negedge clk);
    t0         = tnow;
    sw_start   = sw;
    link_start = lk;
    @(negedge clk);
    sw_start   = 1'b0;
    link_start = 1'b0;
  endtask

  // Walks n matches from base; done_at = -1 means done must stay low.
  task automatic run_matches(input string tag, input logic [TW-1:0] base,
                             input int n, input int last, input int done_at);
    logic [TW-1:0] m;
    m = base;
    for (int j = 0; j < n; j++) begin
      int k;
      k = j % (last + 1);
      m = m + steps[k];
      wait_t(m);
      chk({tag, " pin before match"}, int'(pin), int'(exp_pin));
      @(negedge clk);
      exp_pin = lvls[k];
      chk({tag, " pin after match"}, int'(pin), int'(exp_pin));
      chk({tag, " done"}, int'(done), (j == done_at) ? 1 : 0);
      chk({tag, " busy"}, int'(busy), (j == done_at) ? 0 : 1);
    end
  endtask

  task automatic stop_direct(input logic v);
    @(negedge clk);
    drv_mode = 1'b1;
    drv_val  = v;
    @(negedge clk);
    drv_mode = 1'b0;
    exp_pin  = v;
  endtask

  task automatic t_reset;
    logic [TW-1:0] t;
    chk("R1 pin at reset", int'(pin), 0);
    chk("R1 busy at reset", int'(busy), 0);
    chk("R1 done at reset", int'(done), 0);
    chk("R1 tnow at reset", int'(tnow), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 tnow after release", int'(tnow), 1);
    t = tnow;
    @(negedge clk);
    chk("R2 tnow step", int'(tnow), int'(TW'(t + 1'b1)));
  endtask

  task automatic t_direct;
    @(negedge clk);
    drv_mode = 1'b1;
    drv_val  = 1'b1;
    @(negedge clk);
    chk("R9 pin follows 1", int'(pin), 1);
    drv_val = 1'b0;
    @(negedge clk);
    chk("R9 pin follows 0", int'(pin), 0);
    sw_start   = 1'b1;
    link_start = 1'b1;
    @(negedge clk);
    sw_start   = 1'b0;
    link_start = 1'b0;
    chk("R9 start ignored busy", int'(busy), 0);
    drv_mode = 1'b0;
    repeat (10) @(negedge clk);
    chk("R9 no run after direct", int'(busy), 0);
    chk("R6 pin held after direct", int'(pin), 0);
    exp_pin = 1'b0;
  endtask

  task automatic t_once;
    logic [TW-1:0] t0;
    steps[0] = 10'd5;  lvls[0] = 1'b1;
    steps[1] = 10'd3;  lvls[1] = 1'b0;
    steps[2] = 10'd7;  lvls[2] = 1'b1;
    steps[3] = 10'd2;  lvls[3] = 1'b0;
    load_table(4);
    loop_mode = 2'd0;
    last_idx  = 2'd2;
    ref_sel   = 1'b0;
    do_start(1'b1, 1'b0, t0);
    chk("R3 busy after start", int'(busy), 1);
    run_matches("R4 R6 once", t0, 3, 2, 2);
    repeat (30) @(negedge clk);
    chk("R5 unused entry never fires", int'(pin), 1);
    chk("R6 done stays", int'(done), 1);
  endtask

  task automatic t_counted;
    logic [TW-1:0] t0;
    steps[0] = 10'd4;  lvls[0] = 1'b0;
    steps[1] = 10'd6;  lvls[1] = 1'b1;
    load_table(2);
    loop_mode  = 2'd1;
    loop_count = 4'd3;
    last_idx   = 2'd1;
    do_start(1'b1, 1'b0, t0);
    run_matches("R7 three passes", t0, 6, 1, 5);
    loop_count = 4'd0;
    do_start(1'b0, 1'b1, t0);
    run_matches("R7 count zero", t0, 2, 1, 1);
    repeat (20) @(negedge clk);
    chk("R7 count zero stays done", int'(done), 1);
  endtask

  task automatic t_endless;
    logic [TW-1:0] t0;
    steps[0] = 10'd3;  lvls[0] = 1'b1;
    steps[1] = 10'd5;  lvls[1] = 1'b0;
    load_table(2);
    loop_mode = 2'd2;
    last_idx  = 2'd1;
    do_start(1'b1, 1'b0, t0);
    run_matches("R8 continuous", t0, 9, 1, -1);
    // R11: both strobes together, one restart from entry 0
    do_start(1'b1, 1'b1, t0);
    run_matches("R11 restart", t0, 2, 1, -1);
    stop_direct(1'b0);
    chk("R9 direct stops run", int'(busy), 0);
  endtask

  task automatic t_extref;
    logic [TW-1:0] rt;
    steps[0] = 10'd20; lvls[0] = 1'b1;
    load_table(1);
    loop_mode = 2'd3;
    last_idx  = 2'd0;
    ref_sel   = 1'b1;
    @(negedge clk);
    rt         = tnow + 10'd50;
    ref_time   = rt;
    link_start = 1'b1;
    @(negedge clk);
    link_start = 1'b0;
    run_matches("R3 external reference", rt, 1, 0, 0);
    ref_sel = 1'b0;
  endtask

  task automatic t_wrap;
    logic [TW-1:0] t0;
    steps[0] = 10'd0;  lvls[0] = 1'b0;
    load_table(1);
    loop_mode = 2'd0;
    last_idx  = 2'd0;
    do_start(1'b1, 1'b0, t0);
    run_matches("R4 zero step full period", t0, 1, 0, 0);
    steps[0] = 10'd12; lvls[0] = 1'b1;
    load_table(1);
    wait_t(10'd1018);
    do_start(1'b1, 1'b0, t0);
    chk("R12 start before wrap", int'(t0), 1019);
    run_matches("R12 match across wrap", t0, 1, 0, 0);
  endtask

  task automatic t_pwm;
    logic [TW-1:0] t0;
    int bad;
    steps[0] = 10'd6;  lvls[0] = 1'b1;
    steps[1] = 10'd10; lvls[1] = 1'b1;
    load_table(2);
    loop_mode = 2'd2;
    last_idx  = 2'd1;
    do_start(1'b1, 1'b0, t0);
    run_matches("R10 full duty", t0, 1, 1, -1);
    bad = 0;
    repeat (48) begin
      @(negedge clk);
      if (pin !== 1'b1) bad++;
    end
    chk("R10 full duty held high", bad, 0);
    lvls[0] = 1'b0;
    lvls[1] = 1'b0;
    load_table(2);
    do_start(1'b1, 1'b0, t0);
    run_matches("R10 zero duty", t0, 1, 1, -1);
    bad = 0;
    repeat (48) begin
      @(negedge clk);
      if (pin !== 1'b0) bad++;
    end
    chk("R10 zero duty held low", bad, 0);
    stop_direct(1'b0);
  endtask

  initial begin
    rst_n      = 1'b0;
    tbl_we     = 1'b0;
    tbl_addr   = '0;
    tbl_step   = '0;
    tbl_lvl    = 1'b0;
    loop_mode  = 2'd0;
    loop_count = '0;
    last_idx   = '0;
    ref_sel    = 1'b0;
    ref_time   = '0;
    sw_start   = 1'b0;
    link_start = 1'b0;
    drv_mode   = 1'b0;
    drv_val    = 1'b0;
    exp_pin    = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    t_direct();
    t_once();
    t_counted();
    t_endless();
    t_extref();
    t_wrap();
    t_pwm();
    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule